// File: doc/BRIEF.md
# Cascaded Interval Timer Unit

The block is a chained timebase that runs entirely on one system clock. A 16-bit prescaler divides the clock down to a millisecond enable. An 8-bit stage divides that enable down to a hundred-millisecond enable. Two 7-bit interval channels then count these enables. The fast channel counts millisecond enables and raises a milliseconds interrupt. The slow channel counts hundred-millisecond enables and raises a seconds interrupt. A separate 6-bit divider makes a free-running microsecond strobe. Each stage is a down-counter. When it reaches zero while its enable is high, it emits a single-cycle pulse and reloads its divisor. No derived clocks are used.

Software reaches the block through a byte-wide register bus with an address, a write strobe, a read strobe and write and read data. Read data is combinational from the address. Reads and writes take effect at the clock edge where the strobe is high. The top bit of each write to an interval register chooses how the new count is loaded. In immediate mode the channel counter is loaded at the write edge. In deferred mode the count waits until the running interval expires.

Each interval channel has two state machines. The reload machine has the states CH_RUN (no deferred count waiting) and CH_HOLD (a deferred count waiting). Its transitions are: CH_RUN to CH_HOLD on a deferred write; CH_HOLD to CH_HOLD on a further deferred write, which replaces the waiting count; CH_HOLD to CH_RUN on expiry, which loads the waiting count; and any state to CH_RUN on an immediate write. The flag machine has the states IRQ_IDLE and IRQ_RAISED. It moves from IRQ_IDLE to IRQ_RAISED on expiry. It moves from IRQ_RAISED back to IRQ_IDLE on a read of the channel's address, unless an expiry falls in that same cycle.

Top module: `cascade_timer`

## Requirements
- R1: After reset the registers read as follows: address 0 (milliseconds interval) 0x7F, address 1 (seconds interval) 0x7F, address 2 (microsecond divisor) 0x03, address 3 (prescaler low byte) 0x9F, address 4 (prescaler high byte) 0x00, address 5 (hundred-ms divisor) 0x63. Addresses 6 and 7 read 0x00.
- R2: us_tick pulses for one cycle every F+1 clocks, where F is bits 5..0 of address 2. Bits 7..6 of address 2 read as 0.
- R3: ms_tick pulses every H*256+L+1 clocks, where H is address 4 and L is address 3. A new divisor applies from the next reload.
- R4: hms_tick pulses every (C+1) ms_tick periods, where C is address 5, and it is only ever high together with ms_tick.
- R5: ms_irq is set once every (M+1)*(D+1) clocks, where M is bits 6..0 of address 0 and D is the prescaler divisor.
- R6: sec_irq is set once every (S+1)*(C+1)*(D+1) clocks, where S is bits 6..0 of address 1.
- R7: Bit 7 of addresses 0 and 1 always reads 0. Bits 6..0 return the most recently written count.
- R8: A write to address 0 or 1 with bit 7 clear lets the running interval finish at its old length. The new count governs the following intervals.
- R9: A write to address 0 or 1 with bit 7 set loads the channel counter at the write edge. With the milliseconds prescaler at divisor 0, the flag then rises N+1 cycles after the write edge.
- R10: A read of address 0 clears ms_irq, and a read of address 1 clears sec_irq, from the next cycle. Reads of other addresses leave both flags unchanged.
- R11: If an expiry and a clearing read of the same channel fall in one cycle, the flag stays set.
- R12: Once set, a flag stays set until its clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears the interval flag of the addressed channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| us_tick | output | 1 | Microsecond strobe |
| ms_tick | output | 1 | Millisecond enable pulse |
| hms_tick | output | 1 | Hundred-millisecond enable pulse |
| ms_irq | output | 1 | Milliseconds interval flag |
| sec_irq | output | 1 | Seconds interval flag |

## Verification
The bench sweeps small settings of the prescaler, the hundred-ms divisor and both interval counts, and measures the spacing of the pulses and of the flag rises against the closed-form product. A chain that counted one extra or one fewer step at any stage would be off by a whole factor. Deferred and immediate loads are timed against a write placed just after a flag rise. A design that ignored bit 7 would either stretch or shorten the interval that was running. An interval of zero checks that a clearing read in the same cycle as an expiry does not drop the event. Reads of neighbouring addresses check that only the owning address clears a flag.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

    // register address map
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MS_IV  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC_IV = 3'd1;
    localparam logic [ADDR_W-1:0] A_US_DIV = 3'd2;
    localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_HMS    = 3'd5;

    // number of interval channels: 0 = milliseconds, 1 = seconds
    localparam int N_CH = 2;

    // reload machine of an interval channel
    typedef enum logic [0:0] {
        CH_RUN  = 1'b0,
        CH_HOLD = 1'b1
    } reload_state_t;

    // interrupt flag machine of an interval channel
    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } flag_state_t;

endpackage

// File: rtl/cascade_divider.sv
module cascade_divider #(
    parameter int              DIV_W   = 16,
    parameter logic [DIV_W-1:0] RST_CNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign tick    = step && at_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
        end else if (step) begin
            if (at_zero) begin
                cnt_q <= divisor;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cascade_interval.sv
module cascade_interval
    import cascade_timer_pkg::*;
#(
    parameter int              IV_W    = 7,
    parameter logic [IV_W-1:0] RST_VAL = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            wr_en,
    input  logic            wr_imm,
    input  logic [IV_W-1:0] wr_cnt,
    input  logic            rd_clr,
    output logic            expire,
    output logic            irq,
    output logic [IV_W-1:0] readback
);

    reload_state_t rs_q, rs_nxt;
    flag_state_t   fs_q, fs_nxt;

    logic [IV_W-1:0] cnt_q;
    logic [IV_W-1:0] active_q;
    logic [IV_W-1:0] pending_q;
    logic            wr_defer;

    assign expire   = step && (cnt_q == '0);
    assign wr_defer = wr_en && !wr_imm;

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= CH_RUN;
            fs_q <= IRQ_IDLE;
        end else begin
            rs_q <= rs_nxt;
            fs_q <= fs_nxt;
        end
    end

    // reload machine transitions
    always_comb begin
        rs_nxt = rs_q;
        unique case (rs_q)
            CH_RUN: begin
                if (wr_defer) begin
                    rs_nxt = CH_HOLD;
                end
            end
            CH_HOLD: begin
                if (wr_en && wr_imm) begin
                    rs_nxt = CH_RUN;
                end else if (wr_defer) begin
                    rs_nxt = CH_HOLD;
                end else if (expire) begin
                    rs_nxt = CH_RUN;
                end
            end
            default: rs_nxt = CH_RUN;
        endcase
    end

    // flag machine transitions
    always_comb begin
        fs_nxt = fs_q;
        unique case (fs_q)
            IRQ_IDLE: begin
                if (expire) begin
                    fs_nxt = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                if (rd_clr && !expire) begin
                    fs_nxt = IRQ_IDLE;
                end
            end
            default: fs_nxt = IRQ_IDLE;
        endcase
    end

    // counter and count registers, steered by the reload state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= RST_VAL;
            active_q  <= RST_VAL;
            pending_q <= RST_VAL;
        end else if (wr_en && wr_imm) begin
            cnt_q     <= wr_cnt;
            active_q  <= wr_cnt;
            pending_q <= wr_cnt;
        end else begin
            if (wr_defer) begin
                pending_q <= wr_cnt;
            end
            if (expire) begin
                unique case (rs_q)
                    CH_HOLD: begin
                        cnt_q    <= pending_q;
                        active_q <= pending_q;
                    end
                    default: cnt_q <= active_q;
                endcase
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        irq      = (fs_q == IRQ_RAISED);
        readback = (rs_q == CH_HOLD) ? pending_q : active_q;
    end

endmodule

// File: rtl/cascade_regs.sv
module cascade_regs
    import cascade_timer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int US_W    = 6,
    parameter int HMS_W   = 8,
    parameter int IV_W    = 7,
    parameter logic [US_W-1:0]   US_RST  = 6'h03,
    parameter logic [DATA_W-1:0] LO_RST  = 8'h9F,
    parameter logic [DATA_W-1:0] HI_RST  = 8'h00,
    parameter logic [HMS_W-1:0]  HMS_RST = 8'h63,
    localparam int PRE_W = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [N_CH-1:0][IV_W-1:0]  iv_rb,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [US_W-1:0]            us_div,
    output logic [PRE_W-1:0]           pre_div,
    output logic [HMS_W-1:0]           hms_div,
    output logic [N_CH-1:0]            iv_wr,
    output logic                       iv_imm,
    output logic [IV_W-1:0]            iv_cnt,
    output logic [N_CH-1:0]            iv_clr
);

    logic [DATA_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            us_div  <= US_RST;
            lo_q    <= LO_RST;
            hi_q    <= HI_RST;
            hms_div <= HMS_RST;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_US_DIV: us_div  <= bus_wdata[US_W-1:0];
                A_PRE_LO: lo_q    <= bus_wdata;
                A_PRE_HI: hi_q    <= bus_wdata;
                A_HMS:    hms_div <= bus_wdata[HMS_W-1:0];
                default: ;
            endcase
        end
    end

    assign pre_div = {hi_q, lo_q};
    assign iv_imm  = bus_wdata[DATA_W-1];
    assign iv_cnt  = bus_wdata[IV_W-1:0];

    // per-channel write and clear strobes
    for (genvar c = 0; c < N_CH; c++) begin : g_strobe
        localparam logic [ADDR_W-1:0] CH_ADDR = A_MS_IV + ADDR_W'(c);
        assign iv_wr[c]  = bus_wr && (bus_addr == CH_ADDR);
        assign iv_clr[c] = bus_rd && (bus_addr == CH_ADDR);
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_MS_IV:  bus_rdata = {{(DATA_W-IV_W){1'b0}}, iv_rb[0]};
            A_SEC_IV: bus_rdata = {{(DATA_W-IV_W){1'b0}}, iv_rb[1]};
            A_US_DIV: bus_rdata = {{(DATA_W-US_W){1'b0}}, us_div};
            A_PRE_LO: bus_rdata = lo_q;
            A_PRE_HI: bus_rdata = hi_q;
            A_HMS:    bus_rdata = {{(DATA_W-HMS_W){1'b0}}, hms_div};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import cascade_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int US_W   = 6,
    parameter int HMS_W  = 8,
    parameter int IV_W   = 7,
    localparam int PRE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              us_tick,
    output logic              ms_tick,
    output logic              hms_tick,
    output logic              ms_irq,
    output logic              sec_irq
);

    localparam logic [US_W-1:0]  US_RST  = US_W'(3);
    localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(16'h009F);
    localparam logic [HMS_W-1:0] HMS_RST = HMS_W'(99);
    localparam logic [IV_W-1:0]  IV_RST  = '1;

    logic [US_W-1:0]             us_div;
    logic [PRE_W-1:0]            pre_div;
    logic [HMS_W-1:0]            hms_div;
    logic [N_CH-1:0]             iv_wr;
    logic                        iv_imm;
    logic [IV_W-1:0]             iv_cnt;
    logic [N_CH-1:0]             iv_clr;
    logic [N_CH-1:0][IV_W-1:0]   iv_rb;
    logic [N_CH-1:0]             iv_step;
    logic [N_CH-1:0]             iv_expire;
    logic [N_CH-1:0]             iv_irq;

    cascade_regs #(
        .DATA_W (DATA_W),
        .US_W   (US_W),
        .HMS_W  (HMS_W),
        .IV_W   (IV_W),
        .US_RST (US_RST),
        .LO_RST (PRE_RST[DATA_W-1:0]),
        .HI_RST (PRE_RST[PRE_W-1:DATA_W]),
        .HMS_RST(HMS_RST)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .iv_rb    (iv_rb),
        .bus_rdata(bus_rdata),
        .us_div   (us_div),
        .pre_div  (pre_div),
        .hms_div  (hms_div),
        .iv_wr    (iv_wr),
        .iv_imm   (iv_imm),
        .iv_cnt   (iv_cnt),
        .iv_clr   (iv_clr)
    );

    cascade_divider #(.DIV_W(US_W), .RST_CNT(US_RST)) us_div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (1'b1),
        .divisor(us_div),
        .tick   (us_tick)
    );

    cascade_divider #(.DIV_W(PRE_W), .RST_CNT(PRE_RST)) pre_div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (1'b1),
        .divisor(pre_div),
        .tick   (ms_tick)
    );

    cascade_divider #(.DIV_W(HMS_W), .RST_CNT(HMS_RST)) hms_div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (ms_tick),
        .divisor(hms_div),
        .tick   (hms_tick)
    );

    assign iv_step = {hms_tick, ms_tick};

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        cascade_interval #(.IV_W(IV_W), .RST_VAL(IV_RST)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (iv_step[c]),
            .wr_en   (iv_wr[c]),
            .wr_imm  (iv_imm),
            .wr_cnt  (iv_cnt),
            .rd_clr  (iv_clr[c]),
            .expire  (iv_expire[c]),
            .irq     (iv_irq[c]),
            .readback(iv_rb[c])
        );
    end

    assign ms_irq  = iv_irq[0];
    assign sec_irq = iv_irq[1];

endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk
    import cascade_timer_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              ms_tick,
    input logic              hms_tick,
    input logic              ms_irq,
    input logic              sec_irq,
    input logic [PRE_W-1:0]  pre_div,
    input logic [1:0]        iv_expire
);

    // R4
    hms_with_ms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hms_tick |-> ms_tick);

    // R3
    ms_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && pre_div != '0) |=> !ms_tick);

    // R7
    ctl_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_MS_IV || bus_addr == A_SEC_IV || bus_addr == A_US_DIV)
        |-> !bus_rdata[7]);

    // R12
    ms_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_irq && !(bus_rd && bus_addr == A_MS_IV)) |=> ms_irq);

    // R12
    sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_irq && !(bus_rd && bus_addr == A_SEC_IV)) |=> sec_irq);

    // R11
    ms_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iv_expire[0] |=> ms_irq);

    // R10
    ms_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_MS_IV && !iv_expire[0]) |=> !ms_irq);

    // R10
    sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_SEC_IV && !iv_expire[1]) |=> !sec_irq);

    // R6
    sec_on_hms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iv_expire[1] |-> hms_tick);

endmodule

bind cascade_timer cascade_timer_chk #(.PRE_W(PRE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .ms_tick  (ms_tick),
    .hms_tick (hms_tick),
    .ms_irq   (ms_irq),
    .sec_irq  (sec_irq),
    .pre_div  (pre_div),
    .iv_expire(iv_expire)
);

// File: tb/cascade_timer_tb.sv
`timescale 1ns/1ps
module cascade_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       us_tick, ms_tick, hms_tick, ms_irq, sec_irq;

    int cyc = 0;
    int nvec = 0;
    int nerr = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cascade_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .us_tick  (us_tick),
        .ms_tick  (ms_tick),
        .hms_tick (hms_tick),
        .ms_irq   (ms_irq),
        .sec_irq  (sec_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic sig_of(input int s);
        case (s)
            0: return us_tick;
            1: return ms_tick;
            2: return hms_tick;
            3: return ms_irq;
            default: return sec_irq;
        endcase
    endfunction

    task automatic wait_high(input int s, output int t);
        while (!sig_of(s)) @(negedge clk);
        t = cyc;
    endtask

    // spacing between two pulses of a tick output
    task automatic tick_gap(input int s, output int g);
        int ta, tb;
        wait_high(s, ta);
        @(negedge clk);
        wait_high(s, tb);
        g = tb - ta;
    endtask

    // spacing between two flag rises, clearing in between
    task automatic flag_gap(input int s, output int g);
        logic [7:0] d;
        int ta, tb;
        logic [2:0] a;
        a = (s == 3) ? 3'd0 : 3'd1;
        bus_read(a, d);
        wait_high(s, ta);
        bus_read(a, d);
        wait_high(s, tb);
        g = tb - ta;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int g, t0, t1, t2, c;
        bit first;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and unmapped addresses
        bus_read(3'd0, d); chk("R1 ms interval reset", d, 8'h7F);
        bus_read(3'd1, d); chk("R1 sec interval reset", d, 8'h7F);
        bus_read(3'd2, d); chk("R1 us divisor reset", d, 8'h03);
        bus_read(3'd3, d); chk("R1 prescaler low reset", d, 8'h9F);
        bus_read(3'd4, d); chk("R1 prescaler high reset", d, 8'h00);
        bus_read(3'd5, d); chk("R1 hms divisor reset", d, 8'h63);
        bus_read(3'd6, d); chk("R1 unmapped 6", d, 0);
        bus_read(3'd7, d); chk("R1 unmapped 7", d, 0);
        tick_gap(1, g); chk("R3 default prescaler period", g, 160);

        // R2 microsecond divisor sweep and readback masking
        for (int f = 0; f < 6; f++) begin
            bus_write(3'd2, 8'(f));
            repeat (10) @(negedge clk);
            tick_gap(0, g); chk("R2 us period", g, f + 1);
        end
        bus_write(3'd2, 8'hFF);
        bus_read(3'd2, d); chk("R2 us divisor upper bits", d, 8'h3F);

        // R7 readback of interval registers
        bus_write(3'd0, 8'hFF);
        bus_read(3'd0, d); chk("R7 ms control bit reads 0", d, 8'h7F);
        bus_write(3'd1, 8'h05);
        bus_read(3'd1, d); chk("R7 sec deferred count readback", d, 8'h05);

        // R3 R4 R5 R6 sweep over a small configuration
        first = 1'b1;
        for (int dv = 0; dv < 4; dv++) begin
            for (int h = 0; h < 3; h++) begin
                for (int m = 1; m < 4; m++) begin
                    for (int s = 0; s < 2; s++) begin
                        bus_write(3'd3, 8'(dv));
                        bus_write(3'd4, 8'h00);
                        bus_write(3'd5, 8'(h));
                        bus_write(3'd0, 8'h80 | 8'(m));
                        bus_write(3'd1, 8'h80 | 8'(s));
                        repeat (first ? 20000 : 100) @(negedge clk);
                        first = 1'b0;
                        tick_gap(1, g); chk("R3 ms tick period", g, dv + 1);
                        tick_gap(2, g); chk("R4 hms tick period", g, (h + 1) * (dv + 1));
                        flag_gap(3, g); chk("R5 ms irq interval", g, (m + 1) * (dv + 1));
                        flag_gap(3, g); chk("R5 ms irq interval repeat", g, (m + 1) * (dv + 1));
                        if ((s + 1) * (h + 1) * (dv + 1) >= 2) begin
                            flag_gap(4, g); chk("R6 sec irq interval", g, (s + 1) * (h + 1) * (dv + 1));
                            flag_gap(4, g); chk("R6 sec irq interval repeat", g, (s + 1) * (h + 1) * (dv + 1));
                        end
                    end
                end
            end
        end

        // R8 deferred load: prescaler divisor 0, interval 10 then 4
        bus_write(3'd3, 8'h00);
        bus_write(3'd0, 8'h89);
        repeat (20) @(negedge clk);
        bus_read(3'd0, d);
        wait_high(3, t0);
        bus_read(3'd0, d);
        bus_write(3'd0, 8'h03);
        bus_read(3'd0, d); chk("R8 pending count readback", d, 8'h03);
        wait_high(3, t1);
        chk("R8 running interval kept", t1 - t0, 10);
        bus_read(3'd0, d);
        wait_high(3, t2);
        chk("R8 new interval after expiry", t2 - t1, 4);

        // R9 immediate load
        bus_write(3'd0, 8'h80 | 8'd20);
        repeat (30) @(negedge clk);
        bus_read(3'd0, d);
        wait_high(3, t0);
        bus_read(3'd0, d);
        c = cyc;
        bus_write(3'd0, 8'h80 | 8'd5);
        wait_high(3, t1);
        chk("R9 immediate load timing", t1 - c, 7);

        // R10 R12 other reads do not clear, owner read clears
        repeat (3) @(negedge clk);
        chk("R12 flag held without read", ms_irq, 1);
        bus_read(3'd1, d);
        bus_read(3'd3, d);
        chk("R10 other address read keeps ms_irq", ms_irq, 1);
        bus_write(3'd0, 8'h80 | 8'd30);
        bus_read(3'd0, d);
        chk("R10 owner read clears ms_irq", ms_irq, 0);

        // R11 expiry and read in the same cycle
        bus_write(3'd0, 8'h80);
        repeat (3) @(negedge clk);
        bus_read(3'd0, d);
        chk("R11 flag kept on coincident event", ms_irq, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule